// File: doc/BRIEF.md
# Register-Write Sequence Program Encoder

This block turns a stream of high-level requests into the compact byte program run by a register-write sequencer. Each request arrives on a valid/ready handshake and is one of five operations: a register write, a flag set, a flag wait, a delay, or a finish that closes the program. The encoder keeps the most recent address and data it has placed in the program. For each write it picks the shortest command that reaches the new values. It drops the data command entirely when the data has not changed. It uses a 3-byte form when only the low half differs and a 5-byte form otherwise.

The bytes are packed four to a 32-bit output word, first byte in bits [7:0]. A delay given in nanoseconds is divided by 1000 with a reciprocal multiply, then folded into a one-byte logarithmic code. On finish the program is padded with 0x7F fill bytes. The final word count is reported together with an overflow flag, which compares the count against the configured capacity. The finish also returns the cached address and data to all ones, so the next program starts fresh.

Operation codes on `req_op`: 0 write, 1 flag set, 2 flag wait, 3 delay, 4 finish. Other codes are accepted and dropped.

The control FSM has five states:
- IDLE accepts a request. A write, flag set or wait goes to EMIT, a delay goes to DIVIDE, and a finish goes to PAD.
- DIVIDE waits one cycle for the registered quotient and then goes to EMIT with the delay byte.
- EMIT sends one byte per cycle and returns to IDLE after the last byte.
- PAD sends 0x7F each cycle until a word completes, then goes to CLOSE.
- CLOSE reports the result for one cycle and goes to IDLE.

Top module: `regseq_encoder`

## Requirements
- R1: After reset `req_ready` is 1 and `word_valid` and `prog_done` are 0.
- R2: A write (op 0, address on `req_arg_a`, data on `req_arg_b`) whose data upper 16 bits differ from the cached data emits 0xE2 followed by the four data bytes, least significant first. After reset the cache is all ones.
- R3: A write whose data equals the cached data emits no data command. Only the address command appears.
- R4: A write whose data differs from the cached data only in the low 16 bits emits 0x42 followed by the two low data bytes, least significant first.
- R5: Every write ends with an address command. This is 0xE0 and four address bytes when the upper 16 address bits differ from the cache, else 0x40 and the two low bytes, least significant first.
- R6: A flag set (op 1, flag in `req_arg_a[7:0]`, signed value in `req_arg_b`) emits one byte: 0x80+flag for a negative value, 0xA0+flag for zero, 0xC0+flag for a positive value.
- R7: A flag wait (op 2, flag in `req_arg_a[7:0]`, value in `req_arg_b[7:0]`) emits 0x5F, the flag byte, then the value byte.
- R8: A delay (op 3, nanoseconds in `req_arg_b`) takes u = ns/1000 rounded down. It shifts u right by 2 and counts the shifts s until u < 4, then emits the byte (s<<2)|u.
- R9: Bytes are packed four per word with the earliest byte in bits [7:0]. `word_valid` pulses once per completed word.
- R10: A finish (op 4) appends at least one 0x7F byte and pads to a word boundary, giving (bytes+4)/4 words. `prog_done` pulses in the same cycle as the last word, with `prog_words` holding that count.
- R11: `prog_overflow` is 1 with `prog_done` exactly when the word count exceeds CAPACITY. A count equal to CAPACITY is not an overflow.
- R12: After a finish the cached address and data return to all ones, so the next write again uses both long forms.
- R13: `req_ready` is 0 from the cycle after an accepted request until its bytes have all been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Encoder can take a request |
| req_op | input | 3 | Operation code |
| req_arg_a | input | 32 | Address or flag number |
| req_arg_b | input | 32 | Data, flag value, wait value or nanoseconds |
| word_valid | output | 1 | Packed program word available this cycle |
| word_data | output | 32 | Packed program word |
| prog_done | output | 1 | Program closed this cycle |
| prog_words | output | CNT_W | Word count of the closed program |
| prog_overflow | output | 1 | Word count exceeds CAPACITY |

## Verification
A request is accepted at a rising edge. `req_ready` falls in the same edge, so the bench tests it 1 ns later. The first byte is sent in the next cycle; a delay sends it one cycle after that. A word appears one cycle after its fourth byte, and `prog_done` rises together with the final padded word. Since the word timing depends on how many bytes precede it, the bench collects every word in a monitor at the falling edge and compares the byte stream against the expected program afterwards. Counts and overflow are latched on the `prog_done` cycle.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
    typedef enum logic [2:0] {
        OP_WRITE  = 3'd0,
        OP_SETF   = 3'd1,
        OP_WAIT   = 3'd2,
        OP_DELAY  = 3'd3,
        OP_FINISH = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIVIDE,
        ST_EMIT,
        ST_PAD,
        ST_CLOSE
    } state_e;

    localparam int MAX_CMD_BYTES = 10;
    localparam logic [7:0] FILL_BYTE = 8'h7F;
endpackage

// File: rtl/regseq_cmd_build.sv
module regseq_cmd_build
    import regseq_pkg::*;
#(
    parameter int MAXB = MAX_CMD_BYTES
) (
    input  op_e                 op,
    input  logic [31:0]         arg_a,
    input  logic [31:0]         arg_b,
    input  logic [31:0]         cache_addr,
    input  logic [31:0]         cache_data,
    output logic [8*MAXB-1:0]   bytes,
    output logic [3:0]          len
);
    localparam int HALF = 8 * MAXB / 2;

    logic [HALF-1:0] dvec, avec;
    logic [3:0]      dlen, alen;
    logic [7:0]      setf_base;

    always_comb begin
        dvec = '0;
        avec = '0;
        dlen = 4'd0;
        alen = 4'd0;
        bytes = '0;
        len = 4'd0;
        setf_base = 8'h80;
        unique case (op)
            OP_WRITE: begin
                if (arg_b != cache_data) begin
                    if (arg_b[31:16] != cache_data[31:16]) begin
                        dvec = {arg_b, 8'hE2};
                        dlen = 4'd5;
                    end else begin
                        dvec = {16'h0, arg_b[15:0], 8'h42};
                        dlen = 4'd3;
                    end
                end
                if (arg_a[31:16] != cache_addr[31:16]) begin
                    avec = {arg_a, 8'hE0};
                    alen = 4'd5;
                end else begin
                    avec = {16'h0, arg_a[15:0], 8'h40};
                    alen = 4'd3;
                end
                bytes = {{HALF{1'b0}}, dvec} | ({{HALF{1'b0}}, avec} << {dlen, 3'b000});
                len = dlen + alen;
            end
            OP_SETF: begin
                if (!arg_b[31]) setf_base = (arg_b == 32'd0) ? 8'hA0 : 8'hC0;
                bytes[7:0] = setf_base + arg_a[7:0];
                len = 4'd1;
            end
            OP_WAIT: begin
                bytes[23:0] = {arg_b[7:0], arg_a[7:0], 8'h5F};
                len = 4'd3;
            end
            default: begin
                len = 4'd0;
            end
        endcase
    end
endmodule

// File: rtl/regseq_delay_enc.sv
module regseq_delay_enc #(
    parameter int US_W = 26
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] nsec,
    output logic [7:0]  code
);
    // floor(n/1000) == (n * RECIP) >> SHIFT exactly for every 32-bit n
    localparam logic [63:0] RECIP = 64'd274877907;
    localparam int          SHIFT = 38;
    localparam int          STEPS = (US_W + 1) / 2;

    logic [63:0]     prod;
    logic [US_W-1:0] us_q;
    logic [US_W-1:0] v;
    logic [3:0]      s;

    assign prod = {32'h0, nsec} * RECIP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) us_q <= '0;
        else if (load) us_q <= US_W'(prod >> SHIFT);
    end

    always_comb begin
        v = us_q;
        s = 4'd0;
        for (int i = 0; i < STEPS; i++) begin
            if (v[US_W-1:2] != '0) begin
                v = v >> 2;
                s = s + 4'd1;
            end
        end
        code = {2'b00, s, v[1:0]};
    end

    // R8
    delay_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (us_q != '0) |-> (code != 8'h00));
endmodule

// File: rtl/regseq_packer.sv
module regseq_packer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    input  logic             clear,
    output logic [1:0]       lane,
    output logic             word_valid,
    output logic [31:0]      word_data,
    output logic [CNT_W-1:0] word_count
);
    logic [23:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane       <= 2'd0;
            acc_q      <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
            word_count <= '0;
        end else begin
            word_valid <= 1'b0;
            if (clear) word_count <= '0;
            if (byte_valid) begin
                lane <= lane + 2'd1;
                if (lane == 2'd3) begin
                    word_data  <= {byte_data, acc_q};
                    word_valid <= 1'b1;
                    word_count <= word_count + 1'b1;
                end else begin
                    acc_q[8*lane +: 8] <= byte_data;
                end
            end
        end
    end

    // R9
    pack_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (lane == 2'd0 || $past(byte_valid)));
endmodule

// File: rtl/regseq_encoder.sv
module regseq_encoder
    import regseq_pkg::*;
#(
    parameter int CAPACITY = 128,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [31:0]      req_arg_a,
    input  logic [31:0]      req_arg_b,
    output logic             word_valid,
    output logic [31:0]      word_data,
    output logic             prog_done,
    output logic [CNT_W-1:0] prog_words,
    output logic             prog_overflow
);
    localparam int BUF_W = 8 * MAX_CMD_BYTES;

    state_e           state_q, state_d;
    op_e              op;
    logic [31:0]      addr_q, data_q;
    logic [BUF_W-1:0] buf_q, cmd_bytes;
    logic [3:0]       left_q, cmd_len;
    logic [7:0]       delay_code;
    logic [1:0]       lane;
    logic             fire, byte_valid;
    logic [7:0]       byte_data;
    logic [CNT_W-1:0] count;

    assign op   = op_e'(req_op);
    assign fire = req_valid && req_ready;

    regseq_cmd_build #(.MAXB(MAX_CMD_BYTES)) u_build (
        .op(op), .arg_a(req_arg_a), .arg_b(req_arg_b),
        .cache_addr(addr_q), .cache_data(data_q),
        .bytes(cmd_bytes), .len(cmd_len)
    );

    regseq_delay_enc u_delay (
        .clk(clk), .rst_n(rst_n),
        .load(fire && op == OP_DELAY),
        .nsec(req_arg_b), .code(delay_code)
    );

    regseq_packer #(.CNT_W(CNT_W)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .clear(state_q == ST_CLOSE), .lane(lane),
        .word_valid(word_valid), .word_data(word_data), .word_count(count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (op)
                        OP_WRITE, OP_SETF, OP_WAIT: state_d = ST_EMIT;
                        OP_DELAY:                   state_d = ST_DIVIDE;
                        OP_FINISH:                  state_d = ST_PAD;
                        default:                    state_d = ST_IDLE;
                    endcase
                end
            end
            ST_DIVIDE: state_d = ST_EMIT;
            ST_EMIT:   if (left_q == 4'd1) state_d = ST_IDLE;
            ST_PAD:    if (lane == 2'd3) state_d = ST_CLOSE;
            ST_CLOSE:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '1;
            data_q <= '1;
            buf_q  <= '0;
            left_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (fire && (op == OP_WRITE || op == OP_SETF || op == OP_WAIT)) begin
                        buf_q  <= cmd_bytes;
                        left_q <= cmd_len;
                    end
                    if (fire && op == OP_WRITE) begin
                        addr_q <= req_arg_a;
                        data_q <= req_arg_b;
                    end
                end
                ST_DIVIDE: begin
                    buf_q  <= {{(BUF_W-8){1'b0}}, delay_code};
                    left_q <= 4'd1;
                end
                ST_EMIT: begin
                    buf_q  <= buf_q >> 8;
                    left_q <= left_q - 4'd1;
                end
                ST_CLOSE: begin
                    addr_q <= '1;
                    data_q <= '1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        byte_valid    = (state_q == ST_EMIT) || (state_q == ST_PAD);
        byte_data     = (state_q == ST_PAD) ? FILL_BYTE : buf_q[7:0];
        prog_done     = (state_q == ST_CLOSE);
        prog_words    = count;
        prog_overflow = prog_done && (count > CNT_W'(CAPACITY));
    end

    // R3
    nodata_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == OP_WRITE && req_arg_b == data_q)
            |=> (buf_q[7:0] == 8'h40 || buf_q[7:0] == 8'hE0));

    // R10
    done_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done |-> (word_valid && word_data[31:24] == FILL_BYTE));

    // R13
    emit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMIT) |-> (!req_ready && left_q != 4'd0));

    // R12
    cache_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done |=> (addr_q == '1 && data_q == '1));
endmodule

// File: tb/test_regseq_encoder.sv
module test_regseq_encoder;
    localparam int CAP = 8;
    localparam int CW  = 16;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [3:0]  n;
        logic [79:0] exp;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{3'd0, 32'h00401234, 32'h12345678, 4'd10, 80'h00401234E012345678E2}, // R2 R5 long forms
        '{3'd0, 32'h00405678, 32'h12349ABC, 4'd6,  80'h000000005678409ABC42}, // R4 R5 short forms
        '{3'd0, 32'h00410000, 32'h12349ABC, 4'd5,  80'h0000000000410000E0},   // R3 no data
        '{3'd1, 32'h00000003, 32'hFFFFFFFF, 4'd1,  80'h83},                   // R6 negative
        '{3'd1, 32'h00000003, 32'h00000000, 4'd1,  80'hA3},                   // R6 zero
        '{3'd1, 32'h00000005, 32'h00000007, 4'd1,  80'hC5},                   // R6 positive
        '{3'd2, 32'h00000012, 32'h00000001, 4'd3,  80'h01125F},               // R7
        '{3'd3, 32'h0,        32'd20000,    4'd1,  80'h09},                   // R8
        '{3'd3, 32'h0,        32'd999,      4'd1,  80'h00},                   // R8 below 1 us
        '{3'd3, 32'h0,        32'hFFFFFFFF, 4'd1,  80'h2D},                   // R8 largest
        '{3'd3, 32'h0,        32'd3000,     4'd1,  80'h03}                    // R8 no shift
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_op = 3'd0;
    logic [31:0] req_arg_a = '0, req_arg_b = '0;
    logic word_valid, prog_done, prog_overflow;
    logic [31:0] word_data;
    logic [CW-1:0] prog_words;

    int checks = 0, fails = 0;
    logic [7:0]  got [0:511];
    int          got_n = 0;
    logic [31:0] last_word = '0;
    logic [31:0] first_word = '0;
    bit          done_seen = 0;
    int          done_words = 0;
    logic        done_ovf = 0;

    always #2 clk = ~clk;

    regseq_encoder #(.CAPACITY(CAP), .CNT_W(CW)) i_regseq_encoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_arg_a(req_arg_a), .req_arg_b(req_arg_b),
        .word_valid(word_valid), .word_data(word_data), .prog_done(prog_done),
        .prog_words(prog_words), .prog_overflow(prog_overflow)
    );

    always @(negedge clk) begin
        if (word_valid) begin
            if (got_n == 0) first_word = word_data;
            for (int k = 0; k < 4; k++) got[(got_n + k) % 512] = word_data[8*k +: 8];
            got_n = got_n + 4;
            last_word = word_data;
        end
        if (prog_done) begin
            done_seen  = 1;
            done_words = int'(prog_words);
            done_ovf   = prog_overflow;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op = op; req_arg_a = a; req_arg_b = b; req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic finish_prog();
        done_seen = 0;
        send(3'd4, 32'h0, 32'h0);
        while (!done_seen) @(negedge clk);
    endtask

    function automatic string op_req(input logic [2:0] op);
        case (op)
            3'd0: return "R2/R3/R4/R5 write";
            3'd1: return "R6 setf";
            3'd2: return "R7 wait";
            default: return "R8 delay";
        endcase
    endfunction

    initial begin
        int pos;
        int base;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1, "R1 ready", 32'(req_ready), 32'h1);
        chk(word_valid === 1'b0 && prog_done === 1'b0, "R1 idle outputs",
            32'({word_valid, prog_done}), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < 11; i++) begin
            send(VECS[i].op, VECS[i].a, VECS[i].b);
            if (i == 0) begin
                // R13 busy while bytes are sent
                chk(req_ready === 1'b0, "R13 ready low during emit", 32'(req_ready), 32'h0);
            end
        end
        finish_prog();
        chk(done_words == 8, "R10 word count", 32'(done_words), 32'd8);
        chk(done_ovf === 1'b0, "R11 count equal to capacity", 32'(done_ovf), 32'h0);
        chk(first_word == 32'h345678E2, "R9 little-endian packing", first_word, 32'h345678E2);
        pos = 0;
        for (int i = 0; i < 11; i++) begin
            bit ok = 1;
            logic [79:0] act = '0;
            for (int k = 0; k < int'(VECS[i].n); k++) begin
                act[8*k +: 8] = got[pos + k];
                if (got[pos + k] !== VECS[i].exp[8*k +: 8]) ok = 0;
            end
            chk(ok, op_req(VECS[i].op), act[31:0], VECS[i].exp[31:0]);
            pos = pos + int'(VECS[i].n);
        end
        chk(got[31] == 8'h7F, "R10 single fill byte", 32'(got[31]), 32'h7F);

        // R12 cache cleared by finish: long forms again
        base = got_n;
        send(3'd0, 32'h00405678, 32'h12349ABC);
        finish_prog();
        chk(got[base] == 8'hE2 && got[base + 5] == 8'hE0, "R12 long forms after finish",
            32'({got[base], got[base + 5]}), 32'hE2E0);
        chk(done_words == 3, "R10 count for 10 bytes", 32'(done_words), 32'd3);
        chk(last_word == 32'h7F7F0040, "R10 two fill bytes", last_word, 32'h7F7F0040);

        // R10 full word of fill when bytes are a multiple of four
        send(3'd2, 32'h1, 32'h2);
        send(3'd1, 32'h0, 32'h0);
        finish_prog();
        chk(done_words == 2, "R10 count for 4 bytes", 32'(done_words), 32'd2);
        chk(last_word == 32'h7F7F7F7F, "R10 whole fill word", last_word, 32'h7F7F7F7F);
        chk(done_ovf === 1'b0, "R11 small program", 32'(done_ovf), 32'h0);

        // R11 overflow above capacity: 40 bytes -> 11 words
        for (int k = 0; k < 4; k++)
            send(3'd0, 32'h00010000 * (k + 1), (32'h01000000 * (k + 1)) | 32'h7);
        finish_prog();
        chk(done_words == 11, "R11 count", 32'(done_words), 32'd11);
        chk(done_ovf === 1'b1, "R11 overflow flagged", 32'(done_ovf), 32'h1);
        @(negedge clk);
        chk(prog_done === 1'b0 && req_ready === 1'b1, "R10 done is a pulse",
            32'({prog_done, req_ready}), 32'h1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule